// File: doc/BRIEF.md
# Fault Break Combiner

This block collects every fault that must stop a motor-control timer's power outputs and turns them into one synchronous break request. It has two kinds of source. External fault pins pass through a two-stage synchronizer. Each pin then has its own sample-agreement glitch filter, its own polarity select and its own enable. Internal system faults are already synchronous and each has an enable bit. Their bit order is: bit 0 clock-stuck detector, bit 1 low-voltage lock, bit 2 CPU lockup, bit 3 memory ECC error.

The enabled sources are ORed into one signal. A global polarity stage sets which level of that signal means break. A one-cycle software generate strobe is ORed in after the polarity stage, and a global enable gates the whole result. The registered result is the break level. A one-cycle event pulse marks each rising edge of that level. The event sets a sticky flag that software clears by writing one, and an interrupt is raised while the flag is set and the interrupt enable is on.

Top module: `fault_break_combiner`

## Requirements
- R1: After reset, brk_lvl_o, brk_evt_o, brk_flag_o and brk_irq_o are all 0.
- R2: An internal fault bit whose int_en_i bit is 1 raises brk_lvl_o one clock after it is sampled. A fault bit whose enable is 0 has no effect.
- R3: With filter length 0 (bypass), an enabled external pin that becomes active raises brk_lvl_o three clocks after the pin changes: two synchronizer stages plus the level register.
- R4: An external pin whose ext_en_i bit is 0 has no effect on brk_lvl_o.
- R5: ext_pol_i bit i = 0 makes pin i active high. Bit i = 1 makes pin i active low.
- R6: With a filter length N from 1 to 15, set in ext_flt_len_i bits [4i+3:4i], the filtered pin changes only after N consecutive equal synchronized samples. The level therefore follows a held pin after 3+N clocks, and a pulse shorter than N clocks is rejected.
- R7: glb_pol_i = 1 inverts the combined source signal before the break decision. When no source is active, the block then breaks.
- R8: While glb_en_i is 0, brk_lvl_o is 0 in the following cycle, whatever the sources or the software strobe.
- R9: A one-cycle sw_gen_i strobe forces brk_lvl_o high for one cycle, independent of glb_pol_i, provided glb_en_i is 1.
- R10: brk_evt_o is high for exactly the first cycle of each high period of brk_lvl_o.
- R11: brk_flag_o is set by brk_evt_o and stays set until a cycle with flag_clr_i = 1. If an event and a clear fall in the same cycle, the event wins.
- R12: brk_irq_o is brk_flag_o gated by irq_en_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ext_brk_i | input | NUM_EXT | Asynchronous external fault pins |
| ext_en_i | input | NUM_EXT | Per-pin enable |
| ext_pol_i | input | NUM_EXT | Per-pin polarity, 1 = active low |
| ext_flt_len_i | input | NUM_EXT*4 | Per-pin filter length, 0 = bypass |
| int_fault_i | input | NUM_INT | Synchronous internal fault events |
| int_en_i | input | NUM_INT | Per-internal-source enable |
| glb_en_i | input | 1 | Global break enable |
| glb_pol_i | input | 1 | Global polarity, 1 = inverted combined input |
| sw_gen_i | input | 1 | Software break strobe (one cycle) |
| irq_en_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 1 | Write-one-to-clear strobe for the flag |
| brk_lvl_o | output | 1 | Registered break level |
| brk_evt_o | output | 1 | One-cycle pulse on break onset |
| brk_flag_o | output | 1 | Sticky break flag |
| brk_irq_o | output | 1 | Interrupt request |

## Verification
An internal fault, the software strobe, a global control change or a flag clear shows up at the outputs one clock after the edge that samples it. An external pin change takes three clocks in bypass and 3+N clocks with filter length N. An interrupt-enable change appears at brk_irq_o before the next check. The driver changes inputs on the falling edge and stores each expected output word with the cycle number in which it is due. The monitor compares that word a few nanoseconds after the matching rising edge. Checks are also placed one cycle before the due cycle, to catch a result that arrives too early.

// File: rtl/fbc_pkg.sv
package fbc_pkg;
  localparam int FLT_W = 4;
  typedef logic [FLT_W-1:0] flt_len_t;
endpackage

// File: rtl/fbc_sync.sv
module fbc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= {q[STAGES-2:0], d_i};
  end

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/fbc_filter.sv
module fbc_filter
  import fbc_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     din_i,
  input  flt_len_t len_i,
  output logic     dout_o
);
  flt_len_t cnt_q;
  logic     filt_q;
  logic     diff;

  assign diff = din_i != filt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      filt_q <= 1'b0;
    end else if (len_i == '0) begin
      // bypass: track input so a later length change starts aligned
      cnt_q  <= '0;
      filt_q <= din_i;
    end else if (!diff) begin
      cnt_q <= '0;
    end else if (cnt_q == len_i - flt_len_t'(1)) begin
      cnt_q  <= '0;
      filt_q <= din_i;
    end else begin
      cnt_q <= cnt_q + flt_len_t'(1);
    end
  end

  assign dout_o = (len_i == '0) ? din_i : filt_q;
endmodule

// File: rtl/fbc_ext_path.sv
module fbc_ext_path
  import fbc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     pin_i,
  input  logic     en_i,
  input  logic     pol_i,
  input  flt_len_t len_i,
  output logic     act_o
);
  logic pin_sync;
  logic pin_filt;

  fbc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  fbc_filter u_filt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .din_i (pin_sync),
    .len_i (len_i),
    .dout_o(pin_filt)
  );

  assign act_o = en_i & (pin_filt ^ pol_i);
endmodule

// File: rtl/fault_break_combiner.sv
module fault_break_combiner
  import fbc_pkg::*;
#(
  parameter int NUM_EXT     = 4,
  parameter int NUM_INT     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_EXT-1:0]       ext_brk_i,
  input  logic [NUM_EXT-1:0]       ext_en_i,
  input  logic [NUM_EXT-1:0]       ext_pol_i,
  input  logic [NUM_EXT*FLT_W-1:0] ext_flt_len_i,
  input  logic [NUM_INT-1:0]       int_fault_i,
  input  logic [NUM_INT-1:0]       int_en_i,
  input  logic                     glb_en_i,
  input  logic                     glb_pol_i,
  input  logic                     sw_gen_i,
  input  logic                     irq_en_i,
  input  logic                     flag_clr_i,
  output logic                     brk_lvl_o,
  output logic                     brk_evt_o,
  output logic                     brk_flag_o,
  output logic                     brk_irq_o
);
  logic [NUM_EXT-1:0] ext_act;
  logic [NUM_INT-1:0] int_act;
  logic               src_any;
  logic               lvl_d, evt_d, flag_d;
  logic               lvl_q, evt_q, flag_q;

  for (genvar i = 0; i < NUM_EXT; i++) begin : g_ext
    fbc_ext_path #(.SYNC_STAGES(SYNC_STAGES)) u_path (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .pin_i (ext_brk_i[i]),
      .en_i  (ext_en_i[i]),
      .pol_i (ext_pol_i[i]),
      .len_i (ext_flt_len_i[i*FLT_W +: FLT_W]),
      .act_o (ext_act[i])
    );
  end

  assign int_act = int_fault_i & int_en_i;
  assign src_any = (|ext_act) | (|int_act);

  // software strobe bypasses the polarity stage
  assign lvl_d  = glb_en_i & ((src_any ^ glb_pol_i) | sw_gen_i);
  assign evt_d  = lvl_d & ~lvl_q;
  assign flag_d = evt_d | (flag_q & ~flag_clr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= 1'b0;
      evt_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      lvl_q  <= lvl_d;
      evt_q  <= evt_d;
      flag_q <= flag_d;
    end
  end

  assign brk_lvl_o  = lvl_q;
  assign brk_evt_o  = evt_q;
  assign brk_flag_o = flag_q;
  assign brk_irq_o  = flag_q & irq_en_i;
endmodule

// File: rtl/fbc_checker.sv
module fbc_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic glb_en_i,
  input logic sw_gen_i,
  input logic flag_clr_i,
  input logic brk_lvl_o,
  input logic brk_evt_o,
  input logic brk_flag_o,
  input logic brk_irq_o
);
  assert_evt_in_lvl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_evt_o |-> brk_lvl_o);

  assert_evt_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_evt_o |=> !brk_evt_o);

  assert_evt_on_rise_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_lvl_o && !brk_evt_o) |-> $past(brk_lvl_o));

  assert_glb_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !glb_en_i |=> !brk_lvl_o);

  assert_sw_force_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (glb_en_i && sw_gen_i) |=> brk_lvl_o);

  assert_flag_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_flag_o && !flag_clr_i) |=> brk_flag_o);

  assert_evt_sets_flag_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_evt_o |-> brk_flag_o);

  assert_irq_needs_flag_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_irq_o |-> brk_flag_o);
endmodule

bind fault_break_combiner fbc_checker u_fbc_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .glb_en_i  (glb_en_i),
  .sw_gen_i  (sw_gen_i),
  .flag_clr_i(flag_clr_i),
  .brk_lvl_o (brk_lvl_o),
  .brk_evt_o (brk_evt_o),
  .brk_flag_o(brk_flag_o),
  .brk_irq_o (brk_irq_o)
);

// File: tb/fault_break_combiner_bench.sv
module fault_break_combiner_bench;
  localparam int NE = 4;
  localparam int NI = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NE-1:0] ext_brk_i = '0;
  logic [NE-1:0] ext_en_i = '0;
  logic [NE-1:0] ext_pol_i = '0;
  logic [NE*4-1:0] ext_flt_len_i = '0;
  logic [NI-1:0] int_fault_i = '0;
  logic [NI-1:0] int_en_i = 4'b0111;
  logic          glb_en_i = 1'b1;
  logic          glb_pol_i = 1'b0;
  logic          sw_gen_i = 1'b0;
  logic          irq_en_i = 1'b0;
  logic          flag_clr_i = 1'b0;
  logic          brk_lvl_o, brk_evt_o, brk_flag_o, brk_irq_o;

  fault_break_combiner u_fault_break_combiner (.*);

  always #5 clk_i = ~clk_i;

  typedef struct {
    int         due;
    logic [3:0] v;
    string      tag;
  } item_t;

  item_t sbq[$];
  int    cyc = 0;
  int    checks = 0;
  int    failures = 0;
  bit    done = 1'b0;

  always @(posedge clk_i) cyc <= cyc + 1;

  // v = {lvl, evt, flag, irq}
  task automatic expect_out(input int d, input logic [3:0] v, input string tag);
    item_t it;
    it.due = cyc + d;
    it.v   = v;
    it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic nxt(input int n = 1);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk_i);
      #3;
      for (int i = sbq.size() - 1; i >= 0; i--) begin
        if (sbq[i].due <= cyc) begin
          logic [3:0] act;
          act = {brk_lvl_o, brk_evt_o, brk_flag_o, brk_irq_o};
          checks++;
          if (sbq[i].due < cyc || act !== sbq[i].v) begin
            failures++;
            $display("FAIL %s cycle %0d: got lvl/evt/flag/irq=%b expected %b",
                     sbq[i].tag, cyc, act, sbq[i].v);
          end
          sbq.delete(i);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : driver
    nxt(3);
    rst_ni = 1'b1;
    expect_out(1, 4'b0000, "R1");
    expect_out(2, 4'b0000, "R1");
    nxt(2);

    // internal source, event pulse, flag, irq gating
    int_fault_i = 4'b0100;
    expect_out(1, 4'b1110, "R2");
    expect_out(2, 4'b1010, "R10");
    nxt(2);
    int_fault_i = '0;
    expect_out(1, 4'b0010, "R2");
    nxt();
    irq_en_i = 1'b1;
    expect_out(1, 4'b0011, "R12");
    nxt();
    flag_clr_i = 1'b1;
    expect_out(1, 4'b0000, "R11");
    nxt();
    flag_clr_i = 1'b0;
    irq_en_i = 1'b0;
    int_fault_i = 4'b1000;  // bit 3 disabled
    expect_out(1, 4'b0000, "R2");
    expect_out(3, 4'b0000, "R2");
    nxt(3);
    int_fault_i = '0;
    nxt();

    // external bypass, disabled pin
    ext_en_i = 4'b1010;
    ext_brk_i = 4'b0011;
    expect_out(2, 4'b0000, "R3");
    expect_out(3, 4'b1110, "R3");
    expect_out(4, 4'b1010, "R10");
    nxt(4);
    ext_brk_i = 4'b0001;  // pin0 high but disabled
    expect_out(3, 4'b0010, "R4");
    expect_out(6, 4'b0010, "R4");
    nxt(6);
    flag_clr_i = 1'b1;
    expect_out(1, 4'b0000, "R11");
    nxt();
    flag_clr_i = 1'b0;
    ext_brk_i = '0;
    ext_en_i = '0;
    nxt(4);

    // per-pin active-low polarity
    ext_brk_i = 4'b0100;
    ext_pol_i = 4'b0100;
    nxt(4);
    ext_en_i = 4'b0100;
    expect_out(1, 4'b0000, "R5");
    expect_out(3, 4'b0000, "R5");
    nxt(3);
    ext_brk_i = '0;
    expect_out(3, 4'b1110, "R5");
    nxt(4);
    ext_brk_i = 4'b0100;
    expect_out(3, 4'b0010, "R5");
    nxt(4);
    ext_en_i = '0;
    ext_pol_i = '0;
    ext_brk_i = '0;
    flag_clr_i = 1'b1;
    expect_out(1, 4'b0000, "R11");
    nxt();
    flag_clr_i = 1'b0;
    nxt(3);

    // filter length 4 on pin 0
    ext_flt_len_i = 16'h0004;
    ext_en_i = 4'b0001;
    nxt();
    ext_brk_i = 4'b0001;
    for (int d = 1; d <= 10; d++) expect_out(d, 4'b0000, "R6");
    nxt(3);
    ext_brk_i = '0;
    nxt(10);
    ext_brk_i = 4'b0001;
    expect_out(6, 4'b0000, "R6");
    expect_out(7, 4'b1110, "R6");
    nxt(10);
    ext_brk_i = '0;
    expect_out(6, 4'b1010, "R6");
    expect_out(7, 4'b0010, "R6");
    nxt(8);
    flag_clr_i = 1'b1;
    expect_out(1, 4'b0000, "R11");
    nxt();
    flag_clr_i = 1'b0;
    ext_en_i = '0;
    ext_flt_len_i = '0;
    nxt();

    // global polarity
    glb_pol_i = 1'b1;
    expect_out(1, 4'b1110, "R7");
    nxt(2);
    int_fault_i = 4'b0001;
    expect_out(1, 4'b0010, "R7");
    nxt();
    int_fault_i = '0;
    glb_pol_i = 1'b0;
    flag_clr_i = 1'b1;
    expect_out(1, 4'b0000, "R7");
    nxt();
    flag_clr_i = 1'b0;

    // global enable off
    glb_en_i = 1'b0;
    int_fault_i = 4'b0001;
    expect_out(1, 4'b0000, "R8");
    nxt();
    sw_gen_i = 1'b1;
    expect_out(1, 4'b0000, "R8");
    nxt();
    sw_gen_i = 1'b0;
    int_fault_i = '0;
    nxt();
    glb_en_i = 1'b1;
    nxt();

    // software strobe
    sw_gen_i = 1'b1;
    expect_out(1, 4'b1110, "R9");
    expect_out(2, 4'b0010, "R9");
    nxt();
    sw_gen_i = 1'b0;
    nxt();

    // set wins over clear, irq follows enable
    int_fault_i = 4'b0001;
    flag_clr_i = 1'b1;
    expect_out(1, 4'b1110, "R11");
    nxt();
    int_fault_i = '0;
    flag_clr_i = 1'b0;
    irq_en_i = 1'b1;
    expect_out(1, 4'b0011, "R12");
    nxt();
    irq_en_i = 1'b0;
    expect_out(1, 4'b0010, "R12");
    nxt();
    flag_clr_i = 1'b1;
    expect_out(1, 4'b0000, "R11");
    nxt();
    flag_clr_i = 1'b0;
    nxt(3);

    if (sbq.size() != 0) begin
      failures++;
      $display("FAIL scoreboard: got %0d pending expected 0", sbq.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule